// File: doc/BRIEF.md
# Interruptible DDR Write Burst Command Sequencer

This block sits on the command side of a DDR SDRAM controller. It accepts one request per cycle through a valid/ready handshake and passes legal commands on as issued commands. While a burst write is delivering data, it drives a write-data enable and a beat-pair index. A later WRITE or READ may cut the burst short. A WRITE to any bank takes over at once, and the beat count starts again. A READ ends the write data after the current cycle. The READ is then held back until the internal write-to-read delay has passed. That delay is counted from the clock edge that follows the last data cycle actually accepted.

A burst is eight beats at double data rate, so it takes four clock cycles of data. Data starts in the cycle after the WRITE is issued. A request that carries the auto-precharge bit opens a burst that cannot be interrupted: further commands wait until its data is complete. The requester can set a force input that pushes a command out even when it breaks the timing rules. Any such breach raises a protocol-error flag that stays set until reset. One output marks the cycle in which the first data of an issued READ arrives, for a CAS latency of 2.5 clocks.

The controller is a three-state machine:
- IDLE: no write data is in flight.
- DATA: write data cycles are being accepted.
- WTR: the write data has ended and the write-to-read delay is counting.

Its transitions are:
- IDLE→DATA on an issued WRITE.
- DATA→DATA on an interrupting WRITE.
- DATA→WTR on the last data cycle, or on a pending READ that interrupts the burst.
- DATA→IDLE on a forced READ.
- WTR→DATA on a WRITE.
- WTR→IDLE on an issued READ or when the delay expires.

Top module: `wbi_ctrl`

## Requirements
- R1: After reset: `cmd_out` is NOP, `wr_en` is 0, `rd_data_due` is 0, `proto_err` is 0, and `req_ready` is 1.
- R2: Command codes are 2'b00 NOP, 2'b01 WRITE and 2'b10 READ; 2'b11 is treated as NOP. A WRITE accepted from idle appears on `cmd_out` in the same cycle, with its bank, column and auto-precharge bit. `wr_en` is then high for the next 4 cycles, with `wr_pair` counting 0, 1, 2, 3.
- R3: During a burst opened with `req_ap`=0, a WRITE to any bank is accepted at once. `wr_pair` restarts at 0 in the next cycle, and the data cycles left over from the old burst are dropped.
- R4: During a burst opened with `req_ap`=1, WRITE and READ requests are held with `req_ready` low until the fourth data cycle has passed.
- R5: A READ to the same bank or another bank, requested in data cycle k of an interruptible burst, makes k the last data cycle. The READ is issued TWTR cycles after that last data cycle.
- R6: A READ that follows a completed burst is issued no earlier than TWTR cycles after the fourth data cycle. A READ from idle is issued in the cycle it is requested.
- R7: `wr_en` is 0 in any cycle in which a READ is issued.
- R8: `rd_data_due` is high exactly 2 cycles after a READ is issued.
- R9: A forced READ before the delay has passed, or a forced WRITE into an uninterruptible burst, is still issued. It sets `proto_err` from the next cycle on, and `proto_err` stays set until reset.
- R10: Traffic that follows the handshake never sets `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be issued this cycle |
| req_cmd | input | 2 | Requested command code |
| req_bank | input | BANK_W | Requested bank |
| req_col | input | COL_W | Requested column |
| req_ap | input | 1 | Auto-precharge bit (burst cannot be interrupted) |
| req_force | input | 1 | Issue regardless of timing rules |
| cmd_out | output | 2 | Issued command code |
| cmd_bank | output | BANK_W | Bank of the issued command |
| cmd_col | output | COL_W | Column of the issued command |
| cmd_ap | output | 1 | Auto-precharge bit of the issued command |
| wr_en | output | 1 | Write data accepted this cycle |
| wr_pair | output | PAIR_W | Beat-pair index of the accepted write data |
| rd_data_due | output | 1 | First read data arrives in this cycle's second half |
| proto_err | output | 1 | Sticky timing-violation flag |

## Verification
The assertions check on every cycle the rules that tie the ports together locally:
- no write data is taken in a READ cycle;
- read data is due two cycles after each READ;
- a WRITE is followed by beat pair 0;
- the error flag is sticky;
- nothing is issued without ready or force;
- an uninterruptible burst blocks further WRITEs.

Only the bench's scenarios can show that the truncation point and the exact READ issue cycle match the arithmetic of R5 and R6. The same holds for the restart of the beat count on a WRITE interrupt, for the hold time behind an auto-precharge burst, and for forced breaches raising the flag. The bench sweeps the interrupt cycle for both command kinds, with and without auto-precharge, alternating same-bank and cross-bank targets.

// File: rtl/wbi_pkg.sv
package wbi_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_WR  = 2'b01,
        CMD_RD  = 2'b10,
        CMD_RSV = 2'b11
    } wbi_cmd_e;

    typedef enum logic [1:0] {
        WB_IDLE = 2'd0,
        WB_DATA = 2'd1,
        WB_WTR  = 2'd2
    } wbi_state_e;
endpackage

// File: rtl/wbi_beat_ctr.sv
module wbi_beat_ctr #(
    parameter int PAIRS = 4,
    localparam int PW = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    output logic [PW-1:0] pair,
    output logic          last
);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (advance) cnt_q <= (cnt_q == PW'(PAIRS - 1)) ? '0 : cnt_q + 1'b1;
    end

    assign pair = cnt_q;
    assign last = (cnt_q == PW'(PAIRS - 1));
endmodule

// File: rtl/wbi_wtr_timer.sv
module wbi_wtr_timer #(
    parameter int TWTR = 1,
    localparam int TW = $clog2(TWTR + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= TW'(TWTR - 1);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/wbi_rd_pipe.sv
module wbi_rd_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    output logic rd_due
);
    logic [DEPTH-1:0] sr_q;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= rd_issue;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[DEPTH-2:0], rd_issue};
            end
        end
    endgenerate

    assign rd_due = sr_q[DEPTH-1];
endmodule

// File: rtl/wbi_ctrl.sv
module wbi_ctrl
    import wbi_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 8,
    parameter int TWTR      = 1,
    parameter int CL_WHOLE  = 2,
    localparam int PAIRS    = BURST_LEN / 2,
    localparam int PAIR_W   = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    input  logic              req_force,
    output logic [1:0]        cmd_out,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              wr_en,
    output logic [PAIR_W-1:0] wr_pair,
    output logic              rd_data_due,
    output logic              proto_err
);
    wbi_state_e st_q, st_d;
    logic       cur_ap_q;
    logic       err_q;
    logic       is_wr, is_rd, wr_go, rd_go;
    logic       locked, wtr_ok, violation;
    logic       beat_last, wtr_zero, wtr_load;

    wbi_beat_ctr #(.PAIRS(PAIRS)) u_beat (
        .clk(clk), .rst_n(rst_n), .restart(wr_go),
        .advance(st_q == WB_DATA), .pair(wr_pair), .last(beat_last)
    );

    wbi_wtr_timer #(.TWTR(TWTR)) u_wtr (
        .clk(clk), .rst_n(rst_n), .load(wtr_load), .zero(wtr_zero)
    );

    wbi_rd_pipe #(.DEPTH(CL_WHOLE)) u_rdp (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_go), .rd_due(rd_data_due)
    );

    // Request decode, handshake and issue decision.
    always_comb begin
        is_wr  = req_valid && (req_cmd == CMD_WR);
        is_rd  = req_valid && (req_cmd == CMD_RD);
        locked = (st_q == WB_DATA) && cur_ap_q;
        wtr_ok = (st_q == WB_IDLE) || ((st_q == WB_WTR) && wtr_zero);
        unique case (req_cmd)
            CMD_WR:  req_ready = !locked;
            CMD_RD:  req_ready = wtr_ok;
            default: req_ready = 1'b1;
        endcase
        wr_go     = is_wr && (req_ready || req_force);
        rd_go     = is_rd && (req_ready || req_force);
        violation = (wr_go && locked) || (rd_go && !wtr_ok);
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WB_IDLE: if (wr_go) st_d = WB_DATA;
            WB_DATA: begin
                if (wr_go)                          st_d = WB_DATA;
                else if (rd_go)                     st_d = WB_IDLE;
                else if (beat_last || (is_rd && !cur_ap_q)) st_d = WB_WTR;
            end
            WB_WTR: begin
                if (wr_go)                   st_d = WB_DATA;
                else if (rd_go || wtr_zero)  st_d = WB_IDLE;
            end
            default: st_d = WB_IDLE;
        endcase
        wtr_load = (st_q == WB_DATA) && (st_d == WB_WTR);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= WB_IDLE;
            cur_ap_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            st_q <= st_d;
            if (wr_go)     cur_ap_q <= req_ap;
            if (violation) err_q    <= 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        cmd_out  = wr_go ? CMD_WR : (rd_go ? CMD_RD : CMD_NOP);
        cmd_bank = (wr_go || rd_go) ? req_bank : '0;
        cmd_col  = (wr_go || rd_go) ? req_col  : '0;
        cmd_ap   = (wr_go || rd_go) ? req_ap   : 1'b0;
        wr_en    = (st_q == WB_DATA) && !rd_go;
        proto_err = err_q;
    end
endmodule

// File: rtl/wbi_ctrl_chk.sv
module wbi_ctrl_chk #(
    parameter int PAIR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_cmd,
    input logic              req_force,
    input logic [1:0]        cmd_out,
    input logic              cmd_ap,
    input logic              wr_en,
    input logic [PAIR_W-1:0] wr_pair,
    input logic              rd_data_due,
    input logic              proto_err
);
    p_no_wdata_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == 2'b10) |-> !wr_en);

    p_rd_due_two_later_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == 2'b10) |-> ##2 rd_data_due);

    p_wr_first_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == 2'b01) |=> (wr_en && wr_pair == '0));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    p_issue_needs_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out != 2'b00) |-> (req_valid && (req_ready || req_force)));

    p_ap_burst_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == 2'b01 && cmd_ap) |=> (req_cmd != 2'b01 || !req_ready));
endmodule

bind wbi_ctrl wbi_ctrl_chk #(.PAIR_W(PAIR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_force(req_force), .cmd_out(cmd_out),
    .cmd_ap(cmd_ap), .wr_en(wr_en), .wr_pair(wr_pair),
    .rd_data_due(rd_data_due), .proto_err(proto_err)
);

// File: tb/wbi_ctrl_tb.sv
module wbi_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TWTR       = 2;
    localparam int NCYC       = 14;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_ready, req_ap, req_force;
    logic [1:0] req_cmd, req_bank, cmd_out, cmd_bank, wr_pair;
    logic [9:0] req_col, cmd_col;
    logic       cmd_ap, wr_en, rd_data_due, proto_err;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wbi_ctrl #(.TWTR(TWTR)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap),
        .req_force(req_force), .cmd_out(cmd_out), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cmd_ap(cmd_ap), .wr_en(wr_en), .wr_pair(wr_pair),
        .rd_data_due(rd_data_due), .proto_err(proto_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, let combinational outputs settle.
    task automatic cyc(input logic v, input logic [1:0] c, input logic [1:0] b,
                       input logic [9:0] col, input logic ap, input logic f);
        @(negedge clk);
        req_valid = v; req_cmd = c; req_bank = b; req_col = col;
        req_ap = ap; req_force = f;
        #1;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);
        cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // kind 0: WRITE then READ requested from cycle k; kind 1: WRITE then WRITE at k.
    task automatic run_case(input int kind, input int ap0, input int k);
        int last, iss, epair;
        logic [1:0] b1;
        b1   = (k % 2 == 1) ? 2'd0 : 2'd2;
        last = (ap0 != 0) ? 4 : ((k < 4) ? k : 4);
        if (kind == 0) iss = (k > last + TWTR) ? k : last + TWTR;
        else           iss = (ap0 != 0) ? ((k > 5) ? k : 5) : k;
        for (int c = 0; c < NCYC; c++) begin
            logic ew, er;
            int   ewe;
            if (c == 0)
                cyc(1'b1, 2'b01, 2'd0, 10'h010, ap0[0], 1'b0);
            else if (c >= k && c <= iss)
                cyc(1'b1, (kind == 0) ? 2'b10 : 2'b01, b1, 10'h020 + 10'(k), 1'b0, 1'b0);
            else
                cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);
            ew = (c == 0) || (kind == 1 && c == iss);
            er = (kind == 0 && c == iss);
            chk(kind == 0 ? "R5/R6 read issue cycle" : "R3/R4 write issue cycle",
                cmd_out, ew ? 1 : (er ? 2 : 0));
            if (er || (kind == 1 && c == iss))
                chk("R5 bank of interrupting command", cmd_bank, b1);
            if (c == 0) chk("R2 column passed through", cmd_col, 'h010);
            if (kind == 0) begin
                ewe = (c >= 1 && c <= last) ? 1 : 0;
                epair = c - 1;
            end else begin
                ewe = ((c >= 1 && c <= ((iss < 4) ? iss : 4)) || (c > iss && c <= iss + 4)) ? 1 : 0;
                epair = (c <= iss) ? c - 1 : c - iss - 1;
            end
            chk("R2/R7 wr_en", wr_en, ewe);
            if (ewe == 1) chk("R2/R3 wr_pair", wr_pair, epair);
            chk("R8 rd_data_due", rd_data_due, (kind == 0 && c == iss + 2) ? 1 : 0);
            chk("R10 no error on legal traffic", proto_err, 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_cmd = 2'b00; req_bank = '0;
        req_col = '0; req_ap = 1'b0; req_force = 1'b0;
        do_reset();
        #1;
        chk("R1 cmd after reset", cmd_out, 0);
        chk("R1 wr_en after reset", wr_en, 0);
        chk("R1 rd_data_due after reset", rd_data_due, 0);
        chk("R1 proto_err after reset", proto_err, 0);
        chk("R1 ready after reset", req_ready, 1);

        // Reserved code is a NOP (R2).
        cyc(1'b1, 2'b11, 2'd1, 10'd5, 1'b0, 1'b0);
        chk("R2 reserved code issues nothing", cmd_out, 0);

        // READ from idle (R6, R8).
        cyc(1'b1, 2'b10, 2'd3, 10'd7, 1'b0, 1'b0);
        chk("R6 read from idle immediate", cmd_out, 2);
        cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);
        chk("R8 not due after one cycle", rd_data_due, 0);
        cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);
        chk("R8 due two cycles after read", rd_data_due, 1);
        for (int i = 0; i < 4; i++) cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);

        // Sweeps of interrupt timing.
        for (int ap = 0; ap < 2; ap++) begin
            for (int k = 1; k <= 7; k++) run_case(0, ap, k);
            for (int k = 1; k <= 6; k++) run_case(1, ap, k);
        end

        // Forced READ before the delay (R9, R7).
        do_reset();
        cyc(1'b1, 2'b01, 2'd0, 10'd1, 1'b0, 1'b0);
        cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);
        cyc(1'b1, 2'b10, 2'd1, 10'd2, 1'b0, 1'b1);
        chk("R9 forced read issued", cmd_out, 2);
        chk("R7 wr_en low on forced read", wr_en, 0);
        chk("R9 error not yet set", proto_err, 0);
        cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);
        chk("R9 error raised", proto_err, 1);
        for (int i = 0; i < 5; i++) cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);
        chk("R9 error sticky", proto_err, 1);
        do_reset();
        #1;
        chk("R9 error cleared by reset", proto_err, 0);

        // Forced WRITE into uninterruptible burst (R9, R4).
        cyc(1'b1, 2'b01, 2'd0, 10'd1, 1'b1, 1'b0);
        cyc(1'b1, 2'b01, 2'd2, 10'd3, 1'b0, 1'b0);
        chk("R4 write held during locked burst", req_ready, 0);
        chk("R4 no issue during locked burst", cmd_out, 0);
        cyc(1'b1, 2'b01, 2'd2, 10'd3, 1'b0, 1'b1);
        chk("R9 forced write issued", cmd_out, 1);
        cyc(1'b0, 2'b00, 2'd0, 10'd0, 1'b0, 1'b0);
        chk("R9 error after forced write", proto_err, 1);
        chk("R3 pair restart after forced write", wr_pair, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule